// File: doc/BRIEF.md
# Word Dot-Product Accumulator

This block is a packed SIMD arithmetic unit for a vector datapath. It takes a vector of 32-bit accumulator lanes and two vectors of 16-bit words. For every 32-bit lane it multiplies the two words of A that sit under that lane by the matching two words of B, adds both products to the lane's accumulator, and returns one 32-bit result per lane.

A 2-bit mode field selects how the operands are extended before the multiply: signed A with unsigned B, unsigned A with signed B, or both unsigned. A separate enable chooses between wrapping and clamping accumulation. The clamp range depends on the mode: the mixed-sign modes clamp to the signed 32-bit range, and the all-unsigned mode clamps to the unsigned 32-bit range. The ports always carry the widest vector (`MAX_LANES` lanes). Only `LANES` lanes are computed, for example 4 lanes for a 128-bit configuration, and the lanes above them return zero. Each request is a single cycle with `inValid`, and the result appears on a registered valid/data output one cycle later.

Top module: `wdp_accum`

## Requirements
- R1: Result lane j is formed only from accumulator lane j and the A and B words at indices 2j and 2j+1; word k occupies bits [16k+15:16k] and lane j occupies bits [32j+31:32j].
- R2: In mode 2'b00, each A word is treated as a signed 16-bit value, each B word as unsigned, and the accumulator as signed 32-bit.
- R3: In mode 2'b01, each A word is treated as unsigned, each B word as signed 16-bit, and the accumulator as signed 32-bit.
- R4: In mode 2'b10, both words and the accumulator are treated as unsigned.
- R5: With `satEn` = 0, each lane result is the exact three-term sum reduced modulo 2^32.
- R6: With `satEn` = 1 in modes 2'b00 and 2'b01, a lane sum above 2^31−1 returns 32'h7FFFFFFF, a sum below −2^31 returns 32'h80000000, and a sum in range is returned unchanged.
- R7: With `satEn` = 1 in mode 2'b10, a lane sum above 2^32−1 returns 32'hFFFFFFFF, and an accumulator with bit 31 set is not treated as negative.
- R8: Mode 2'b11 is reserved and returns all-zero lanes, whatever the operands and `satEn` are.
- R9: Result lanes at index `LANES` and above are always zero, and input words above the active lanes have no effect on the active lanes.
- R10: A request accepted with `inValid` high appears on `result`, with `outValid` high, at the next rising edge. When `inValid` is low, `outValid` falls and `result` holds its last value. Back-to-back requests produce back-to-back results.
- R11: Synchronous active-high reset clears `outValid` and `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Request strobe; operands are sampled while it is high |
| mode | input | 2 | Operand signedness: 00 signed·unsigned, 01 unsigned·signed, 10 unsigned·unsigned, 11 reserved |
| satEn | input | 1 | 1 selects clamping, 0 selects wrapping |
| accIn | input | MAX_LANES*32 | Accumulator lanes |
| opA | input | MAX_LANES*32 | First word vector, 2*MAX_LANES words |
| opB | input | MAX_LANES*32 | Second word vector, 2*MAX_LANES words |
| outValid | output | 1 | Result valid, one cycle after the request |
| result | output | MAX_LANES*32 | Result lanes; lanes above LANES are zero |

## Verification
The hardest cases to reach are the ones where the accumulator is in range on its own but the two products push the three-term sum past a 32-bit limit. Detecting these depends on a sum that is wider than 32 bits, and the same accumulator bit pattern has to be read as negative in the mixed modes and as large positive in the all-unsigned mode. To reach them, directed vectors place the accumulator a few counts below a limit (7FFFFFF0, 80000000, FFFFFFF0) and pair it with extreme words such as 7FFF, 8000 and FFFF in each mode. The same accumulator value is then applied with clamping on and off. A seeded random sweep over all modes and both clamp settings completes the coverage.

// File: rtl/wdp_pkg.sv
package wdp_pkg;

  // Operand signedness selector; the encoding is visible on the mode port.
  typedef enum logic [1:0] {
    MODE_SU   = 2'b00,
    MODE_US   = 2'b01,
    MODE_UU   = 2'b10,
    MODE_RSVD = 2'b11
  } dotMode_e;

  // Strobes from control to datapath for one request.
  typedef struct packed {
    logic load;          // capture a new result
    logic aSigned;       // sign-extend A words
    logic bSigned;       // sign-extend B words
    logic accSigned;     // sign-extend the accumulator
    logic clampSigned;   // clamp to signed 32-bit range
    logic clampUnsigned; // clamp to unsigned 32-bit range
    logic zeroOut;       // reserved mode: force zero lanes
  } wdpStrobe_t;

endpackage

// File: rtl/wdp_lane.sv
module wdp_lane #(
  parameter int WORD_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic [ACC_W-1:0]  accIn,
  input  logic [WORD_W-1:0] aLo,
  input  logic [WORD_W-1:0] aHi,
  input  logic [WORD_W-1:0] bLo,
  input  logic [WORD_W-1:0] bHi,
  input  logic              aSigned,
  input  logic              bSigned,
  input  logic              accSigned,
  input  logic              clampSigned,
  input  logic              clampUnsigned,
  output logic [ACC_W-1:0]  laneOut
);

  // A 17x17 signed product fits in 34 bits. The three-term sum needs two
  // more bits, so the sum is carried with four guard bits.
  localparam int PROD_W = 2 * (WORD_W + 1);
  localparam int SUM_W  = ACC_W + 4;
  localparam int PX_W   = PROD_W - WORD_W;
  localparam int SX_W   = SUM_W - PROD_W;
  localparam int AX_W   = SUM_W - ACC_W;

  logic signed [PROD_W-1:0] aLoX, aHiX, bLoX, bHiX;
  logic signed [PROD_W-1:0] prodLo, prodHi;
  logic [SUM_W-1:0] accX, prodLoX, prodHiX, laneSum;
  logic [AX_W:0]    signedHead;
  logic [AX_W-1:0]  unsignedHead;
  logic             signedFits, unsignedFits;

  assign aLoX = {{PX_W{aSigned & aLo[WORD_W-1]}}, aLo};
  assign aHiX = {{PX_W{aSigned & aHi[WORD_W-1]}}, aHi};
  assign bLoX = {{PX_W{bSigned & bLo[WORD_W-1]}}, bLo};
  assign bHiX = {{PX_W{bSigned & bHi[WORD_W-1]}}, bHi};

  assign prodLo = aLoX * bLoX;
  assign prodHi = aHiX * bHiX;

  assign prodLoX = {{SX_W{prodLo[PROD_W-1]}}, prodLo};
  assign prodHiX = {{SX_W{prodHi[PROD_W-1]}}, prodHi};
  assign accX    = {{AX_W{accSigned & accIn[ACC_W-1]}}, accIn};

  assign laneSum = accX + prodLoX + prodHiX;

  // The sum is in the signed range when all bits from bit ACC_W-1 up agree.
  // It is in the unsigned range when all bits from bit ACC_W up are zero.
  assign signedHead   = laneSum[SUM_W-1:ACC_W-1];
  assign unsignedHead = laneSum[SUM_W-1:ACC_W];
  assign signedFits   = (&signedHead) | ~(|signedHead);
  assign unsignedFits = ~(|unsignedHead);

  always_comb begin
    laneOut = laneSum[ACC_W-1:0];
    if (clampSigned && !signedFits) begin
      laneOut = laneSum[SUM_W-1] ? {1'b1, {(ACC_W-1){1'b0}}}
                                 : {1'b0, {(ACC_W-1){1'b1}}};
    end else if (clampUnsigned && !unsignedFits) begin
      laneOut = laneSum[SUM_W-1] ? {ACC_W{1'b0}} : {ACC_W{1'b1}};
    end
  end

endmodule

// File: rtl/wdp_ctrl.sv
module wdp_ctrl
  import wdp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [1:0] mode,
  input  logic       satEn,
  output wdpStrobe_t strobes,
  output logic       outValid
);

  always_comb begin
    strobes      = '0;
    strobes.load = inValid;
    case (dotMode_e'(mode))
      MODE_SU: begin
        strobes.aSigned     = 1'b1;
        strobes.accSigned   = 1'b1;
        strobes.clampSigned = satEn;
      end
      MODE_US: begin
        strobes.bSigned     = 1'b1;
        strobes.accSigned   = 1'b1;
        strobes.clampSigned = satEn;
      end
      MODE_UU: begin
        strobes.clampUnsigned = satEn;
      end
      default: begin
        strobes.zeroOut = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

endmodule

// File: rtl/wdp_datapath.sv
module wdp_datapath
  import wdp_pkg::*;
#(
  parameter int MAX_LANES = 8,
  parameter int LANES     = 4,
  parameter int WORD_W    = 16,
  parameter int ACC_W     = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  wdpStrobe_t                 strobes,
  input  logic [MAX_LANES*ACC_W-1:0] accIn,
  input  logic [2*MAX_LANES*WORD_W-1:0] opA,
  input  logic [2*MAX_LANES*WORD_W-1:0] opB,
  output logic [MAX_LANES*ACC_W-1:0] result
);

  localparam int VEC_W = MAX_LANES * ACC_W;

  logic [VEC_W-1:0] laneGated;

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
    localparam bit ACTIVE = (j < LANES);
    logic [ACC_W-1:0] laneRes;

    wdp_lane #(.WORD_W(WORD_W), .ACC_W(ACC_W)) u_lane (
      .accIn        (accIn[j*ACC_W +: ACC_W]),
      .aLo          (opA[(2*j)*WORD_W +: WORD_W]),
      .aHi          (opA[(2*j+1)*WORD_W +: WORD_W]),
      .bLo          (opB[(2*j)*WORD_W +: WORD_W]),
      .bHi          (opB[(2*j+1)*WORD_W +: WORD_W]),
      .aSigned      (strobes.aSigned),
      .bSigned      (strobes.bSigned),
      .accSigned    (strobes.accSigned),
      .clampSigned  (strobes.clampSigned),
      .clampUnsigned(strobes.clampUnsigned),
      .laneOut      (laneRes)
    );

    // Lanes beyond the configured width are forced to zero; their
    // arithmetic is constant-gated and trimmed away.
    assign laneGated[j*ACC_W +: ACC_W] = ACTIVE ? laneRes : {ACC_W{1'b0}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
    end else if (strobes.load) begin
      result <= strobes.zeroOut ? {VEC_W{1'b0}} : laneGated;
    end
  end

endmodule

// File: rtl/wdp_accum.sv
module wdp_accum
  import wdp_pkg::*;
#(
  parameter int MAX_LANES = 8,
  parameter int LANES     = 4,
  parameter int WORD_W    = 16,
  parameter int ACC_W     = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          inValid,
  input  logic [1:0]                    mode,
  input  logic                          satEn,
  input  logic [MAX_LANES*ACC_W-1:0]    accIn,
  input  logic [2*MAX_LANES*WORD_W-1:0] opA,
  input  logic [2*MAX_LANES*WORD_W-1:0] opB,
  output logic                          outValid,
  output logic [MAX_LANES*ACC_W-1:0]    result
);

  wdpStrobe_t strobes;

  wdp_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .mode    (mode),
    .satEn   (satEn),
    .strobes (strobes),
    .outValid(outValid)
  );

  wdp_datapath #(
    .MAX_LANES(MAX_LANES),
    .LANES    (LANES),
    .WORD_W   (WORD_W),
    .ACC_W    (ACC_W)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .accIn  (accIn),
    .opA    (opA),
    .opB    (opB),
    .result (result)
  );

endmodule

// File: rtl/wdp_accum_chk.sv
module wdp_accum_chk #(
  parameter int MAX_LANES = 8,
  parameter int LANES     = 4,
  parameter int ACC_W     = 32
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       inValid,
  input logic [1:0]                 mode,
  input logic                       outValid,
  input logic [MAX_LANES*ACC_W-1:0] result
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid); // R10

  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid); // R10

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(result)); // R10

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (inValid && mode == 2'b11) |=> (result == '0)); // R8

  if (LANES < MAX_LANES) begin : g_upper
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
      result[MAX_LANES*ACC_W-1:LANES*ACC_W] == '0); // R9
  end

endmodule

bind wdp_accum wdp_accum_chk #(
  .MAX_LANES(MAX_LANES),
  .LANES    (LANES),
  .ACC_W    (ACC_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .inValid (inValid),
  .mode    (mode),
  .outValid(outValid),
  .result  (result)
);

// File: tb/wdp_accum_test.sv
module wdp_accum_test;

  localparam int MAXL  = 8;
  localparam int LN    = 4;
  localparam int VEC_W = MAXL * 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [1:0] mode = 2'b00;
  logic satEn = 1'b0;
  logic [VEC_W-1:0] accIn = '0;
  logic [VEC_W-1:0] opA = '0;
  logic [VEC_W-1:0] opB = '0;
  logic outValid;
  logic [VEC_W-1:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  wdp_accum #(.MAX_LANES(MAXL), .LANES(LN)) uut (
    .clk(clk), .rst(rst), .inValid(inValid), .mode(mode), .satEn(satEn),
    .accIn(accIn), .opA(opA), .opB(opB), .outValid(outValid), .result(result)
  );

  // ---------------- reference model, written from the requirements -------
  function automatic longint extWord(logic [15:0] w, bit sgn);
    longint v = longint'(w);
    if (sgn && w[15]) v = v - 65536;
    return v;
  endfunction

  function automatic logic [31:0] refLane(logic [1:0] m, bit sat, logic [31:0] acc,
                                          logic [15:0] a0, logic [15:0] a1,
                                          logic [15:0] b0, logic [15:0] b1);
    longint s;
    bit sa = (m == 2'b00);
    bit sb = (m == 2'b01);
    if (m == 2'b11) return 32'h0;
    s = (m == 2'b10) ? longint'(acc) : longint'($signed(acc));
    s = s + extWord(a0, sa) * extWord(b0, sb) + extWord(a1, sa) * extWord(b1, sb);
    if (sat) begin
      if (m == 2'b10) begin
        if (s > 64'sd4294967295) s = 64'sd4294967295;
        if (s < 0) s = 0;
      end else begin
        if (s > 64'sd2147483647) s = 64'sd2147483647;
        if (s < -64'sd2147483648) s = -64'sd2147483648;
      end
    end
    return s[31:0];
  endfunction

  function automatic logic [VEC_W-1:0] refVec(logic [1:0] m, bit sat,
      logic [VEC_W-1:0] acc, logic [VEC_W-1:0] a, logic [VEC_W-1:0] b);
    logic [VEC_W-1:0] v = '0;
    for (int j = 0; j < LN; j++) begin
      v[j*32 +: 32] = refLane(m, sat, acc[j*32 +: 32],
                              a[(2*j)*16 +: 16], a[(2*j+1)*16 +: 16],
                              b[(2*j)*16 +: 16], b[(2*j+1)*16 +: 16]);
    end
    return v;
  endfunction

  // ---------------- check helpers -----------------------------------------
  task automatic checkVec(string req, logic [VEC_W-1:0] act, logic [VEC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: result actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkBit(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Drive one request on a falling edge, capture edge follows, sample on the
  // next falling edge and compare.
  task automatic applyOne(string req, logic [1:0] m, bit sat,
      logic [VEC_W-1:0] acc, logic [VEC_W-1:0] a, logic [VEC_W-1:0] b);
    @(negedge clk);
    inValid = 1'b1; mode = m; satEn = sat; accIn = acc; opA = a; opB = b;
    @(negedge clk);
    inValid = 1'b0;
    checkBit(req, "outValid", outValid, 1'b1);
    checkVec(req, result, refVec(m, sat, acc, a, b));
  endtask

  function automatic logic [VEC_W-1:0] lane0(logic [31:0] acc);
    logic [VEC_W-1:0] v = '0;
    v[31:0] = acc;
    return v;
  endfunction

  function automatic logic [VEC_W-1:0] words01(logic [15:0] w0, logic [15:0] w1);
    logic [VEC_W-1:0] v = '0;
    v[15:0] = w0; v[31:16] = w1;
    return v;
  endfunction

  // ---------------- scenarios ---------------------------------------------
  task automatic testReset();
    checkBit("R11", "outValid after reset", outValid, 1'b0);
    checkVec("R11", result, '0);
  endtask

  task automatic testPairing();
    logic [VEC_W-1:0] a = '0, b = '0;
    logic [VEC_W-1:0] exp = '0;
    a[2*16 +: 16] = 16'd3; a[3*16 +: 16] = 16'd5;
    b[2*16 +: 16] = 16'd7; b[3*16 +: 16] = 16'd11;
    exp[32 +: 32] = 32'd76;
    applyOne("R1", 2'b10, 1'b0, '0, a, b);
    checkVec("R1", result, exp);
  endtask

  task automatic testSignedness();
    logic [VEC_W-1:0] a = words01(16'hFFFF, 16'h8000);
    logic [VEC_W-1:0] b = words01(16'hFFFF, 16'h0002);
    applyOne("R2", 2'b00, 1'b0, lane0(32'd10), a, b);
    checkVec("R2", result[31:0], 32'hFFFE000B);
    applyOne("R3", 2'b01, 1'b0, lane0(32'd10), a, b);
    checkVec("R3", result[31:0], 32'd11);
    applyOne("R4", 2'b10, 1'b0, lane0(32'd10), a, b);
    checkVec("R4", result[31:0], 32'hFFFF000B);
  endtask

  task automatic testWrap();
    applyOne("R5", 2'b10, 1'b0, lane0(32'hFFFFFFFF), words01(16'd2, 16'd0),
             words01(16'd3, 16'd0));
    checkVec("R5", result[31:0], 32'd5);
    applyOne("R5", 2'b00, 1'b0, lane0(32'h7FFFFFFF), words01(16'd1, 16'd0),
             words01(16'd1, 16'd0));
    checkVec("R5", result[31:0], 32'h80000000);
  endtask

  task automatic testSignedClamp();
    applyOne("R6", 2'b00, 1'b1, lane0(32'h7FFFFFF0), words01(16'h7FFF, 16'h7FFF),
             words01(16'hFFFF, 16'hFFFF));
    checkVec("R6", result[31:0], 32'h7FFFFFFF);
    applyOne("R6", 2'b01, 1'b1, lane0(32'h80000000), words01(16'hFFFF, 16'd0),
             words01(16'h8000, 16'd0));
    checkVec("R6", result[31:0], 32'h80000000);
    applyOne("R6", 2'b00, 1'b1, lane0(32'h00001000), words01(16'hFFFE, 16'd0),
             words01(16'd4, 16'd0));
    checkVec("R6", result[31:0], 32'h00000FF8);
  endtask

  task automatic testUnsignedClamp();
    applyOne("R7", 2'b10, 1'b1, lane0(32'hFFFFFFF0), words01(16'hFFFF, 16'd0),
             words01(16'hFFFF, 16'd0));
    checkVec("R7", result[31:0], 32'hFFFFFFFF);
    applyOne("R7", 2'b10, 1'b1, lane0(32'h80000000), words01(16'd1, 16'd0),
             words01(16'd1, 16'd0));
    checkVec("R7", result[31:0], 32'h80000001);
  endtask

  task automatic testReserved();
    applyOne("R8", 2'b11, 1'b0, {VEC_W{1'b1}}, {VEC_W{1'b1}}, {VEC_W{1'b1}});
    checkVec("R8", result, '0);
    applyOne("R8", 2'b11, 1'b1, {VEC_W{1'b1}}, {VEC_W{1'b1}}, {VEC_W{1'b1}});
    checkVec("R8", result, '0);
  endtask

  task automatic testUpperLanes();
    logic [VEC_W-1:0] acc = '0, a = '0, b = '0;
    for (int j = 0; j < LN; j++) begin
      acc[j*32 +: 32] = 32'd100 * (j + 1);
      a[(2*j)*16 +: 16] = 16'(j + 2);
      b[(2*j)*16 +: 16] = 16'(j + 3);
    end
    acc[VEC_W-1:LN*32] = '1; a[VEC_W-1:LN*32] = '1; b[VEC_W-1:LN*32] = '1;
    applyOne("R9", 2'b10, 1'b0, acc, a, b);
    checkVec("R9", result[VEC_W-1:LN*32], '0);
    checkVec("R9", result[31:0], 32'd106);
  endtask

  task automatic testTiming();
    logic [VEC_W-1:0] held;
    logic [VEC_W-1:0] a1 = words01(16'd9, 16'd1), b1 = words01(16'd9, 16'd1);
    logic [VEC_W-1:0] a2 = words01(16'd4, 16'd4), b2 = words01(16'd5, 16'd5);
    // back-to-back requests
    @(negedge clk);
    inValid = 1'b1; mode = 2'b10; satEn = 1'b0; accIn = '0; opA = a1; opB = b1;
    @(negedge clk);
    opA = a2; opB = b2;
    checkBit("R10", "outValid first", outValid, 1'b1);
    checkVec("R10", result[31:0], 32'd82);
    @(negedge clk);
    inValid = 1'b0;
    checkBit("R10", "outValid second", outValid, 1'b1);
    checkVec("R10", result[31:0], 32'd40);
    held = result;
    // idle cycles with changing operands
    for (int k = 0; k < 3; k++) begin
      opA = {VEC_W{1'b1}} ^ VEC_W'(k); accIn = VEC_W'(k * 77); mode = 2'(k);
      @(negedge clk);
      checkBit("R10", "outValid idle", outValid, 1'b0);
      checkVec("R10", result, held);
    end
  endtask

  task automatic testMidReset();
    applyOne("R11", 2'b10, 1'b0, lane0(32'd5), words01(16'd1, 16'd0),
             words01(16'd1, 16'd0));
    @(negedge clk);
    rst = 1'b1; inValid = 1'b1;
    @(negedge clk);
    rst = 1'b0; inValid = 1'b0;
    checkBit("R11", "outValid in reset", outValid, 1'b0);
    checkVec("R11", result, '0);
  endtask

  task automatic testRandom();
    for (int n = 0; n < 80; n++) begin
      logic [VEC_W-1:0] acc, a, b;
      logic [1:0] m = 2'($urandom_range(0, 3));
      bit sat = 1'($urandom_range(0, 1));
      string req;
      for (int w = 0; w < VEC_W / 32; w++) begin
        acc[w*32 +: 32] = $urandom();
        a[w*32 +: 32]   = $urandom();
        b[w*32 +: 32]   = $urandom();
      end
      case (m)
        2'b00:   req = sat ? "R6" : "R2";
        2'b01:   req = sat ? "R6" : "R3";
        2'b10:   req = sat ? "R7" : "R4";
        default: req = "R8";
      endcase
      applyOne(req, m, sat, acc, a, b);
    end
  endtask

  // ---------------- sequencing --------------------------------------------
  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testPairing();
    testSignedness();
    testWrap();
    testSignedClamp();
    testUnsignedClamp();
    testReserved();
    testUpperLanes();
    testTiming();
    testMidReset();
    testRandom();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule